// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Controller

This block is the memory side of a three-wire serial EEPROM link. A host raises chip select, clocks in a leading 1 as the start bit, then a 2-bit opcode, an address and, for programming instructions, a data word. All of it arrives MSB first on the serial data input and is sampled on rising serial-clock edges. The block decodes seven instructions: read, write, erase, erase-all, write-all, write-enable and write-disable. Reads shift a stored word back out on the data output. Programming instructions start a self-timed cycle of `PROG_CYCLES` system clocks. That cycle keeps running after chip select drops. While it runs, the block reports busy or ready on the data output whenever chip select is raised again.

The storage is an on-chip register array. Parameter `WIDE` chooses the organization. With `WIDE` = 0 the array is 512 words of 8 bits with a 9-bit address. With `WIDE` = 1 it is 256 words of 16 bits with an 8-bit address. The serial clock, data input and chip select are first brought into the system clock domain through `SYNC_STAGES` flip-flops. Rising serial-clock edges are then found in that domain.

The controller state machine has five states:
- ST_WAIT: chip select high, looking for the start bit.
- ST_HEAD: collecting the opcode and address.
- ST_WDATA: collecting write data.
- ST_RDATA: shifting read data out.
- ST_HOLD: frame complete, all input ignored.

Its transitions are:
- start detected: ST_WAIT to ST_HEAD.
- header decoded: ST_HEAD to ST_RDATA, ST_WDATA or ST_HOLD, depending on the instruction.
- data complete: ST_WDATA to ST_HOLD.
- last bit sent: ST_RDATA to ST_HOLD.
- deselect: any state to ST_WAIT while chip select is low.

Top module: `mw_eeprom`

## Requirements
- R1: While synchronized chip select is low, the controller returns to ST_WAIT and `sdo_en` is 0. A program cycle already started still completes.
- R2: While chip select is high and before a start bit, rising serial clocks with data 0 have no effect. The first 1 sampled is the start bit.
- R3: The opcode bits after the start bit, first bit on the left, decode as 10 = read, 01 = write and 11 = erase. For opcode 00, the two most significant address bits select the instruction: 10 = erase-all, 00 = write-disable, 11 = write-enable, 01 = write-all.
- R4: With `WIDE` = 0 the address is 9 bits, MSB first. Erase, erase-all, write-enable and write-disable use 12 rising clocks including the start bit. Read, write and write-all use 20.
- R5: With `WIDE` = 1 the address is 8 bits and data is 16 bits, MSB first. The short instructions use 11 clocks and read, write and write-all use 27.
- R6: For a read, `sdo_en` is 1 and `sdo` carries the word's MSB after the rising edge that samples the last address bit. Each later rising edge advances one bit. After the edge that follows the LSB, `sdo_en` returns to 0.
- R7: After a frame completes, further serial clocks and data are ignored until chip select goes low.
- R8: Reset clears the write-enable latch. Erase, write, erase-all and write-all do nothing unless write-enable has executed since the last write-disable or reset. An ignored instruction starts no program cycle and drives no status.
- R9: Erase sets the addressed word to all ones. Erase-all sets every word to all ones. Write-all sets every word to the supplied data. Reset leaves every word at all ones.
- R10: A program cycle is busy for `PROG_CYCLES` system clocks, starting the cycle after the final instruction bit is detected. Its memory update is visible when it ends. If chip select is raised again while busy, `sdo_en` is 1 and `sdo` is 0. Once ready, `sdo` is 1.
- R11: Write-enable and write-disable never drive `sdo`. Status is only shown after chip select is raised again, and it stays shown until the next start bit. Start bits are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high, asynchronous to clk |
| sclk | input | 1 | Serial clock from the host, asynchronous to clk |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output value (read data or ready/busy) |
| sdo_en | output | 1 | Output enable for sdo; 0 means high impedance |

## Verification
A miscounted bit counter or a wrong decode shows up at the ports within one frame. Read data comes back shifted or from the wrong word, or `sdo_en` stays high past the last data bit. A wrong write-enable latch or a wrong pending-operation register only shows on the next read of the affected words, about one frame later. Busy-counter faults show as a status low phase that is too short or too long, measured in system clocks from the final instruction bit. Status that ignores the chip-select history shows as `sdo_en` high while deselected, which is caught every clock after a few cycles of settling.

// File: rtl/mw_pkg.sv
`timescale 1ns/1ps
package mw_pkg;

    typedef enum logic [2:0] {
        ST_WAIT  = 3'd0,
        ST_HEAD  = 3'd1,
        ST_WDATA = 3'd2,
        ST_RDATA = 3'd3,
        ST_HOLD  = 3'd4
    } mw_state_e;

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } mw_op_e;

    typedef enum logic [1:0] {
        SUB_DIS   = 2'b00,
        SUB_WRALL = 2'b01,
        SUB_ERALL = 2'b10,
        SUB_EN    = 2'b11
    } mw_sub_e;

endpackage

// File: rtl/mw_sync.sv
`timescale 1ns/1ps
module mw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sclk,
    input  logic sdi,
    output logic cs_s,
    output logic sdi_s,
    output logic sclk_rise
);
    logic [STAGES-1:0] cs_p;
    logic [STAGES-1:0] sclk_p;
    logic [STAGES-1:0] sdi_p;
    logic              sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_p   <= '0;
            sclk_p <= '0;
            sdi_p  <= '0;
            sclk_d <= 1'b0;
        end else begin
            cs_p   <= {cs_p[STAGES-2:0], cs};
            sclk_p <= {sclk_p[STAGES-2:0], sclk};
            sdi_p  <= {sdi_p[STAGES-2:0], sdi};
            sclk_d <= sclk_p[STAGES-1];
        end
    end

    assign cs_s      = cs_p[STAGES-1];
    assign sdi_s     = sdi_p[STAGES-1];
    assign sclk_rise = sclk_p[STAGES-1] & ~sclk_d;
endmodule

// File: rtl/mw_store.sv
`timescale 1ns/1ps
module mw_store #(
    parameter int DW = 8,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_one,
    input  logic          we_all,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (we_all || (we_one && wr_addr == AW'(i))) mem[i] <= wr_data;
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/mw_ctrl.sv
`timescale 1ns/1ps
module mw_ctrl
    import mw_pkg::*;
#(
    parameter int DW          = 8,
    parameter int AW          = 9,
    parameter int PROG_CYCLES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          sdi_s,
    input  logic          sclk_rise,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    output logic          we_one,
    output logic          we_all,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          sdo,
    output logic          sdo_en
);
    localparam int HDR    = AW + 2;
    localparam int MAXB   = (HDR > DW) ? HDR : DW;
    localparam int CNT_W  = $clog2(MAXB + 1);
    localparam int BUSY_W = $clog2(PROG_CYCLES + 1);

    mw_state_e   state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [HDR-2:0]    hdr_sr;
    logic [DW-2:0]     din_sr;
    logic [DW-1:0]     dout_sr;
    logic [AW-1:0]     addr_q;
    logic              wrall_q;
    logic              wen_q;
    logic              stat_pend;
    logic [BUSY_W-1:0] busy_cnt;
    logic              busy;
    logic              pend_all;
    logic [AW-1:0]     pend_addr;
    logic [DW-1:0]     pend_data;

    logic [HDR-1:0] hdr_now;
    mw_op_e         op_now;
    mw_sub_e        sub_now;
    logic [AW-1:0]  addr_now;
    logic           start_ok, hdr_last, data_last, rd_last;
    logic           launch_erase, launch_write, commit;

    assign hdr_now   = {hdr_sr, sdi_s};
    assign op_now    = mw_op_e'(hdr_now[HDR-1:HDR-2]);
    assign addr_now  = hdr_now[AW-1:0];
    assign sub_now   = mw_sub_e'(addr_now[AW-1:AW-2]);
    assign busy      = (busy_cnt != '0);
    assign start_ok  = (state == ST_WAIT) && cs_s && sclk_rise && sdi_s && !busy;
    assign hdr_last  = (state == ST_HEAD) && sclk_rise && (cnt == CNT_W'(HDR - 1));
    assign data_last = (state == ST_WDATA) && sclk_rise && (cnt == CNT_W'(DW - 1));
    assign rd_last   = (state == ST_RDATA) && sclk_rise && (cnt == CNT_W'(DW - 1));

    assign launch_erase = hdr_last && wen_q &&
                          ((op_now == OP_ERASE) ||
                           (op_now == OP_EXT && sub_now == SUB_ERALL));
    assign launch_write = data_last && wen_q;
    assign commit       = (busy_cnt == BUSY_W'(1));

    assign rd_addr = addr_now;
    assign we_one  = commit && !pend_all;
    assign we_all  = commit && pend_all;
    assign wr_addr = pend_addr;
    assign wr_data = pend_data;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT:  if (start_ok) state_nx = ST_HEAD;
            ST_HEAD: begin
                if (hdr_last) begin
                    unique case (op_now)
                        OP_READ:  state_nx = ST_RDATA;
                        OP_WRITE: state_nx = ST_WDATA;
                        OP_ERASE: state_nx = ST_HOLD;
                        OP_EXT:   state_nx = (sub_now == SUB_WRALL) ? ST_WDATA : ST_HOLD;
                        default:  state_nx = ST_HOLD;
                    endcase
                end
            end
            ST_WDATA: if (data_last) state_nx = ST_HOLD;
            ST_RDATA: if (rd_last)   state_nx = ST_HOLD;
            ST_HOLD:  state_nx = ST_HOLD;
            default:  state_nx = ST_WAIT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state <= ST_WAIT;
        else if (!cs_s) state <= ST_WAIT;
        else            state <= state_nx;
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            hdr_sr  <= '0;
            din_sr  <= '0;
            dout_sr <= '0;
            addr_q  <= '0;
            wrall_q <= 1'b0;
            wen_q   <= 1'b0;
        end else begin
            if (!cs_s) begin
                cnt <= '0;
            end else if (sclk_rise) begin
                unique case (state)
                    ST_WAIT:  cnt <= '0;
                    ST_HEAD:  cnt <= hdr_last ? '0 : cnt + 1'b1;
                    ST_WDATA, ST_RDATA: cnt <= cnt + 1'b1;
                    default:  cnt <= cnt;
                endcase
            end
            if (state == ST_HEAD && sclk_rise) hdr_sr <= hdr_now[HDR-2:0];
            if (state == ST_WDATA && sclk_rise) din_sr <= {din_sr[DW-3:0], sdi_s};
            if (hdr_last) begin
                addr_q  <= addr_now;
                wrall_q <= (op_now == OP_EXT);
                if (op_now == OP_READ) dout_sr <= rd_data;
                if (op_now == OP_EXT && sub_now == SUB_EN)  wen_q <= 1'b1;
                if (op_now == OP_EXT && sub_now == SUB_DIS) wen_q <= 1'b0;
            end else if (state == ST_RDATA && sclk_rise) begin
                dout_sr <= dout_sr << 1;
            end
        end
    end

    // self-timed program engine, independent of chip select
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt  <= '0;
            stat_pend <= 1'b0;
            pend_all  <= 1'b0;
            pend_addr <= '0;
            pend_data <= '0;
        end else begin
            if (launch_erase) begin
                busy_cnt  <= BUSY_W'(PROG_CYCLES);
                pend_all  <= (op_now == OP_EXT);
                pend_addr <= addr_now;
                pend_data <= '1;
            end else if (launch_write) begin
                busy_cnt  <= BUSY_W'(PROG_CYCLES);
                pend_all  <= wrall_q;
                pend_addr <= addr_q;
                pend_data <= {din_sr, sdi_s};
            end else if (busy) begin
                busy_cnt <= busy_cnt - 1'b1;
            end
            if (launch_erase || launch_write) stat_pend <= 1'b1;
            else if (start_ok)                stat_pend <= 1'b0;
        end
    end

    // output process
    always_comb begin
        sdo_en = 1'b0;
        sdo    = 1'b0;
        unique case (state)
            ST_RDATA: begin
                sdo_en = 1'b1;
                sdo    = dout_sr[DW-1];
            end
            ST_WAIT: begin
                sdo_en = cs_s && stat_pend;
                sdo    = !busy;
            end
            default: begin
                sdo_en = 1'b0;
                sdo    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mw_eeprom.sv
`timescale 1ns/1ps
module mw_eeprom #(
    parameter int WIDE        = 0,
    parameter int PROG_CYCLES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sclk,
    input  logic sdi,
    output logic sdo,
    output logic sdo_en
);
    localparam int DW = (WIDE != 0) ? 16 : 8;
    localparam int AW = (WIDE != 0) ? 8 : 9;

    logic          cs_s, sdi_s, sclk_rise;
    logic          we_one, we_all;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [DW-1:0] rd_data, wr_data;

    mw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdi(sdi),
        .cs_s(cs_s), .sdi_s(sdi_s), .sclk_rise(sclk_rise)
    );

    mw_ctrl #(.DW(DW), .AW(AW), .PROG_CYCLES(PROG_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sdi_s(sdi_s), .sclk_rise(sclk_rise),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .we_one(we_one), .we_all(we_all), .wr_addr(wr_addr), .wr_data(wr_data),
        .sdo(sdo), .sdo_en(sdo_en)
    );

    mw_store #(.DW(DW), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .we_one(we_one), .we_all(we_all),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: rtl/mw_eeprom_chk.sv
`timescale 1ns/1ps
module mw_eeprom_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic sdo,
    input logic sdo_en,
    input logic busy,
    input logic wen,
    input logic we_one,
    input logic we_all
);
    // R1: deselected for two cycles means no drive
    a_r1_deselect_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && $past(!cs_s)) |-> !sdo_en);

    // R10: status driven while busy reads low
    a_r10_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_en && busy) |-> !sdo);

    // R8: memory only changes with the enable latch set
    a_r8_commit_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (we_one || we_all) |-> wen);

    // R10: commit is the last busy cycle
    a_r10_commit_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (we_one || we_all) |=> !busy);

    // R10: busy never ends without a commit
    a_r10_fall_commits: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(we_one || we_all));

    // R9: one update kind at a time
    a_r9_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_one && we_all));
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sdo(sdo), .sdo_en(sdo_en),
    .busy(u_ctrl.busy), .wen(u_ctrl.wen_q), .we_one(we_one), .we_all(we_all)
);

// File: tb/mw_eeprom_bench.sv
`timescale 1ns/1ps
module mw_eeprom_bench;
    localparam int PN = 200;
    localparam int PW = 120;

    logic clk = 0, rst_n = 0, cs_n = 0, cs_w = 0, sclk = 0, sdi = 0;
    logic sdo_n, en_n, sdo_w, en_w;
    int   checks = 0, errors = 0;
    bit   sel = 0;
    bit   done = 0;
    int   lo_n = 0, lo_w = 0;

    always #2 clk = ~clk;

    mw_eeprom #(.WIDE(0), .PROG_CYCLES(PN)) u_mw_eeprom (
        .clk(clk), .rst_n(rst_n), .cs(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo_n), .sdo_en(en_n));
    mw_eeprom #(.WIDE(1), .PROG_CYCLES(PW)) u_mw_eeprom_w (
        .clk(clk), .rst_n(rst_n), .cs(cs_w), .sclk(sclk), .sdi(sdi),
        .sdo(sdo_w), .sdo_en(en_w));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // every clock: a deselected device never drives (R1)
    always @(negedge clk) begin
        lo_n = cs_n ? 0 : lo_n + 1;
        lo_w = cs_w ? 0 : lo_w + 1;
        if (rst_n && !done) begin
            if (lo_n > 6) chk("R1 narrow deselected sdo_en", int'(en_n), 0);
            if (lo_w > 6) chk("R1 wide deselected sdo_en", int'(en_w), 0);
        end
    end

    function automatic int aw(); return sel ? 8 : 9; endfunction
    function automatic int dw(); return sel ? 16 : 8; endfunction

    task automatic set_cs(input bit v);
        if (sel) cs_w = v; else cs_n = v;
        repeat (8) @(negedge clk);
    endtask

    task automatic clk_bit(input bit b, output bit d, output bit e);
        sdi = b;
        repeat (8) @(negedge clk);
        d = sel ? sdo_w : sdo_n;
        e = sel ? en_w : en_n;
        sclk = 1;
        repeat (8) @(negedge clk);
        sclk = 0;
    endtask

    task automatic send(input int v, input int n);
        bit d, e;
        for (int i = n - 1; i >= 0; i--) clk_bit(v[i], d, e);
    endtask

    task automatic header(input int op, input int addr, input int pre);
        set_cs(0);
        set_cs(1);
        send(0, pre);
        send(1, 1);
        send(op, 2);
        send(addr, aw());
    endtask

    function automatic int ext(input int sub); return sub << (aw() - 2); endfunction

    task automatic read_word(input int addr, output int val);
        bit d, e;
        int en_bad = 0;
        header(2, addr, 0);
        val = 0;
        for (int i = 0; i < dw(); i++) begin
            clk_bit(0, d, e);
            val = (val << 1) | int'(d);
            if (!e) en_bad++;
        end
        chk("R6 sdo_en low during read data", en_bad, 0);
        clk_bit(0, d, e);
        chk("R6 sdo_en after last read bit", int'(e), 0);
    endtask

    task automatic do_read(input string tag, input int addr, input int exp);
        int v;
        read_word(addr, v);
        set_cs(0);
        chk(tag, v, exp);
    endtask

    task automatic do_write(input int addr, input int data);
        header(1, addr, 0); send(data, dw()); set_cs(0);
    endtask
    task automatic do_erase(input int addr); header(3, addr, 0); set_cs(0); endtask
    task automatic do_ext(input int sub);    header(0, ext(sub), 0); set_cs(0); endtask
    task automatic do_wral(input int data);
        header(0, ext(1), 0); send(data, dw()); set_cs(0);
    endtask
    task automatic settle(); repeat ((sel ? PW : PN) + 30) @(negedge clk); endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit d, e;
        int v, n;
        repeat (10) @(negedge clk);
        chk("R1 reset sdo_en narrow", int'(en_n), 0);
        chk("R1 reset sdo_en wide", int'(en_w), 0);
        rst_n = 1;
        repeat (5) @(negedge clk);

        // R1: clocks with data 1 while deselected do nothing
        send(32'hFFFF_FFFF, 12);

        // R9 reset content, R3 read decode, R4 20-clock read
        do_read("R9 reset word all ones", 5, 'hFF);

        // R8: write while disabled is ignored, no status
        do_write(5, 'h3C);
        set_cs(1);
        chk("R8 ignored write drives no status", int'(en_n), 0);
        set_cs(0);
        settle();
        do_read("R8 disabled write ignored", 5, 'hFF);

        // R11: enable drives nothing
        do_ext(3);
        set_cs(1);
        chk("R11 enable leaves sdo off", int'(en_n), 0);
        set_cs(0);

        // R2 leading zeros, R10 status timing
        header(1, 5, 3); send('h3C, 8);
        set_cs(0);
        set_cs(1);
        chk("R10 status enabled while busy", int'(en_n), 1);
        chk("R10 status low while busy", int'(sdo_n), 0);
        n = 0;
        while (sdo_n == 0 && n < 2000) begin @(negedge clk); n++; end
        v = n + 24;
        chk("R10 busy length lower bound", int'(v >= PN), 1);
        chk("R10 busy length upper bound", int'(v <= PN + 8), 1);
        chk("R10 ready reads high", int'(sdo_n), 1);
        set_cs(0);
        do_read("R2 write after leading zeros", 5, 'h3C);

        // R7: bits after a finished read frame are ignored
        read_word(5, v);
        send(1, 1); send(1, 2); send(5, 9); send(0, 8);
        set_cs(0);
        settle();
        do_read("R7 trailing frame ignored", 5, 'h3C);

        // R1: program cycle survives deselect; R11 no status while low
        do_write(9, 'hA5);
        repeat (20) @(negedge clk);
        chk("R11 no status while deselected", int'(en_n), 0);
        settle();
        set_cs(1);
        chk("R11 status after cycle enabled", int'(en_n), 1);
        chk("R11 status after cycle ready", int'(sdo_n), 1);
        set_cs(0);
        do_read("R1 write completed while deselected", 9, 'hA5);

        // R1: frame aborted by deselect
        set_cs(1); send(1, 1); send(1, 2); send(0, 4); set_cs(0);
        settle();
        do_read("R1 aborted erase frame no effect", 9, 'hA5);

        // R9 erase, R4 12-clock erase
        do_erase(9); settle();
        do_read("R9 erase gives all ones", 9, 'hFF);

        // R9 write-all and erase-all, R3 extended decode
        do_wral('h5A); settle();
        do_read("R9 write-all word 0", 0, 'h5A);
        do_read("R9 write-all word 511", 511, 'h5A);
        do_read("R3 write-all word 5", 5, 'h5A);
        do_ext(2); settle();
        do_read("R9 erase-all word 0", 0, 'hFF);
        do_read("R3 erase-all word 300", 300, 'hFF);

        // R8: disable blocks writes again
        do_ext(0);
        do_write(7, 'h11); settle();
        do_read("R8 write after disable ignored", 7, 'hFF);

        // R5: wide organization
        sel = 1;
        do_read("R5 wide reset word", 'h12, 'hFFFF);
        do_ext(3);
        do_write('h12, 'hBEEF); settle();
        do_read("R5 wide write readback", 'h12, 'hBEEF);
        do_read("R5 wide neighbour untouched", 'h13, 'hFFFF);
        do_erase('h12); settle();
        do_read("R5 wide erase", 'h12, 'hFFFF);

        done = 1;
        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule